// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port sitting on a simple APB-style register bus. It keeps a direction register and an output data register, and drives each pad through separate output and output-enable vectors. Pad inputs are brought in through a two-flop synchronizer before software can see them.

Pin data is reached through an address window in which the word address itself is the bit mask. Address bit n+2 selects pin n. A single write therefore changes exactly the chosen pins, so no read-modify-write sequence is needed to flip one line. A read through the same window returns only the selected pins and zero elsewhere. The direction register sits just above the window. Every transfer completes in one cycle.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction and output data registers are all zero, so every output-enable and output bit is 0.
- R2: A bus write with the address in the data window (offset below 0x400) updates output data bit n from write-data bit n only where address bit n+2 is 1; every other data bit keeps its value.
- R3: A data write has no effect on a bit whose direction bit is 0, and the old value is what appears when that pin is later switched to output.
- R4: A read in the data window returns the pin value for bits whose address mask bit (bit n+2) is 1 and zero for all other bits.
- R5: The direction register is read and written at offset 0x400; bit value 1 makes the pin an output, and output-enable bit n equals direction bit n.
- R6: The pin value of an output pin is its driven data bit; the pin value of an input pin is the pad input as sampled two clock edges earlier.
- R7: Reads at any offset other than the data window and 0x400 return zero, and writes there change no state.
- R8: A write takes effect on the clock edge where psel, penable and pwrite are all high, read data is valid in that same access cycle, and pready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Select for this port |
| penable_i | input | 1 | Access phase of a transfer |
| pwrite_i | input | 1 | 1 for a write, 0 for a read |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 8 | Write data |
| prdata_o | output | 8 | Read data, zero when not reading |
| pready_o | output | 1 | Always ready, no wait states |
| gpio_in_i | input | 8 | Pad input levels |
| gpio_out_o | output | 8 | Pad output levels |
| gpio_oe_o | output | 8 | Pad output enables |

## Verification
The masked window is driven with walking single-bit masks, the full mask, an empty mask and random masks. These separate a decoder that reads the wrong address bits from one that merely mis-merges the data. Random mixes of direction settings and pad levels tell apart readback taken from the driven register and readback taken from the synchronized pad, and they expose writes that leak into input pins. A directed sequence writes while the pins are inputs and then switches them to outputs, which shows whether the write was wrongly retained. Random unmapped offsets confirm that those offsets read zero and leave the registers untouched.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned NPINS   = 8;
  localparam int unsigned AW      = 12;
  localparam int unsigned MASK_LO = 2;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
#(
  parameter int unsigned N_PINS = NPINS,
  parameter int unsigned ADDR_W = AW
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_data_o,
  output logic              is_dir_o,
  output logic [N_PINS-1:0] mask_o
);
  localparam int unsigned HI_LO = N_PINS + MASK_LO;
  localparam int unsigned WIDX_W = ADDR_W - MASK_LO;
  localparam logic [WIDX_W-1:0] DIR_WIDX = WIDX_W'(1) << N_PINS;

  logic unused_lsbs;
  assign unused_lsbs = ^addr_i[MASK_LO-1:0];

  assign is_data_o = (addr_i[ADDR_W-1:HI_LO] == '0);
  assign is_dir_o  = (addr_i[ADDR_W-1:MASK_LO] == DIR_WIDX);
  assign mask_o    = addr_i[HI_LO-1:MASK_LO];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_data_i,
  input  logic              wr_dir_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] data_o,
  output logic [N_PINS-1:0] dir_o
);
  logic [N_PINS-1:0] data_q, dir_q, wmask;

  // only pins that are outputs now accept data
  assign wmask = mask_i & dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_dir_i)  dir_q  <= wdata_i;
      if (wr_data_i) data_q <= (data_q & ~wmask) | (wdata_i & wmask);
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;

  AST_IN_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0)); // R3
  AST_DATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data_i |=> $stable(data_q)); // R2
  AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (((data_q ^ $past(data_q)) & ~$past(mask_i)) == '0)); // R2
  AST_DIR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(dir_q)); // R5
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned N_PINS = NPINS,
  parameter int unsigned ADDR_W = AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [N_PINS-1:0] pwdata_i,
  output logic [N_PINS-1:0] prdata_o,
  output logic              pready_o,
  input  logic [N_PINS-1:0] gpio_in_i,
  output logic [N_PINS-1:0] gpio_out_o,
  output logic [N_PINS-1:0] gpio_oe_o
);
  logic              is_data, is_dir, wr_acc, rd_acc;
  logic [N_PINS-1:0] mask, data, dir, pad_sync, pin_val;

  gpio_addr_dec #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (paddr_i),
    .is_data_o(is_data),
    .is_dir_o (is_dir),
    .mask_o   (mask)
  );

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_in_i),
    .q_o   (pad_sync)
  );

  assign wr_acc = psel_i & penable_i & pwrite_i;
  assign rd_acc = psel_i & ~pwrite_i;

  gpio_port_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_data_i(wr_acc & is_data),
    .wr_dir_i (wr_acc & is_dir),
    .mask_i   (mask),
    .wdata_i  (pwdata_i),
    .data_o   (data),
    .dir_o    (dir)
  );

  assign pin_val = (dir & data) | (~dir & pad_sync);

  always_comb begin
    prdata_o = '0;
    if (rd_acc) begin
      if (is_data)     prdata_o = pin_val & mask;
      else if (is_dir) prdata_o = dir;
    end
  end

  assign pready_o   = 1'b1;
  assign gpio_out_o = data;
  assign gpio_oe_o  = dir;

  AST_RD_UNSEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && is_data) |-> ((prdata_o & ~mask) == '0)); // R4
  AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !is_data && !is_dir) |-> (prdata_o == '0)); // R7
  AST_UNMAPPED_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && !is_data && !is_dir) |=> ($stable(gpio_out_o) && $stable(gpio_oe_o))); // R7
  AST_OUT_PIN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && is_data) |-> (((prdata_o ^ gpio_out_o) & gpio_oe_o & mask) == '0)); // R6
endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  localparam int PER = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0] pwdata = '0, gpio_in = '0;
  logic [7:0] prdata, gpio_out, gpio_oe;
  logic       pready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PER/2) clk = ~clk;

  gpio_mask_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .gpio_in_i(gpio_in), .gpio_out_o(gpio_out), .gpio_oe_o(gpio_oe)
  );

  // reference model
  logic [7:0] m_dir, m_data;
  logic [7:0] pad_hist[$];

  function automatic logic [7:0] m_sync();
    return (pad_hist.size() == 2) ? pad_hist[0] : 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 8'h00; m_data = 8'h00; pad_hist.delete();
    end else begin
      if (psel && penable && pwrite) begin
        if (paddr < 12'h400) begin
          for (int b = 0; b < 8; b++)
            if (paddr[b+2] && m_dir[b]) m_data[b] = pwdata[b];
        end else if (paddr[11:2] == 10'h100) m_dir = pwdata;
      end
      pad_hist.push_back(gpio_in);
      if (pad_hist.size() > 2) void'(pad_hist.pop_front());
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] pins, exp_rd;
      string tag;
      pins = 8'h00;
      for (int b = 0; b < 8; b++) pins[b] = m_dir[b] ? m_data[b] : m_sync()[b];
      exp_rd = 8'h00; tag = "R7";
      if (paddr < 12'h400) begin
        tag = "R4";
        if (psel && !pwrite)
          for (int b = 0; b < 8; b++) exp_rd[b] = paddr[b+2] & pins[b];
      end else if (paddr[11:2] == 10'h100) begin
        tag = "R5";
        if (psel && !pwrite) exp_rd = m_dir;
      end
      chk(tag, prdata, exp_rd);
      chk("R2", gpio_out, m_data);
      chk("R5", gpio_oe, m_dir);
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic logic [11:0] maddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  initial begin
    #(PER*150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    chk("R1", gpio_oe, 8'h00);
    chk("R1", gpio_out, 8'h00);
    chk("R8", {7'd0, pready}, 8'h01);
    rst_n = 1;

    // R3: write while inputs, then switch to outputs
    bus_wr(maddr(8'hFF), 8'hA5);
    bus_wr(12'h400, 8'hFF);
    @(negedge clk) chk("R3", gpio_out, 8'h00);
    bus_rd(12'h400, rd); chk("R5", rd, 8'hFF);

    // R2: walking single-bit masks
    for (int b = 0; b < 8; b++) bus_wr(maddr(8'(1) << b), 8'hFF);
    @(negedge clk) chk("R2", gpio_out, 8'hFF);
    bus_wr(maddr(8'h00), 8'h00);
    @(negedge clk) chk("R2", gpio_out, 8'hFF);
    bus_wr(maddr(8'h0F), 8'h00);
    bus_rd(maddr(8'h3C), rd); chk("R4", rd, 8'h30);

    // R8: write visible right after its edge
    @(negedge clk); psel = 1; pwrite = 1; paddr = maddr(8'h01); pwdata = 8'h01;
    @(negedge clk); penable = 1;
    @(negedge clk); chk("R8", gpio_out, 8'hF1); psel = 0; penable = 0; pwrite = 0;

    // R6: input pin readback latency
    bus_wr(12'h400, 8'h0F);
    gpio_in = 8'hF0;
    @(negedge clk); psel = 1; pwrite = 0; paddr = maddr(8'hF0);
    chk("R6", prdata, 8'h00);
    @(negedge clk) chk("R6", prdata, 8'hF0);
    gpio_in = 8'h50;
    @(negedge clk) chk("R6", prdata, 8'hF0);
    @(negedge clk) chk("R6", prdata, 8'h50);
    psel = 0;

    // R7: unmapped offsets
    bus_wr(12'h404, 8'h00);
    bus_wr(12'h800, 8'hFF);
    bus_rd(12'h404, rd); chk("R7", rd, 8'h00);
    chk("R7", gpio_oe, 8'h0F);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      gpio_in = r[31:24];
      case (r[1:0])
        2'd0: bus_wr(12'h400, r[15:8]);
        2'd1: bus_wr(maddr(r[23:16]), r[15:8]);
        2'd2: bus_rd(maddr(r[23:16]), rd);
        default: if (r[2]) bus_wr({r[23:14], 2'b01} | 12'h400, r[15:8]);
                 else bus_rd(r[23:12] | 12'h404, rd);
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule